// File: doc/BRIEF.md
# Two-Port Command/Data Buffer Access Controller

This block is the slave side of a parallel processor bus. It gives a processor access to an internal buffer of 16-bit words and to a small transfer-length register, and it uses only two port addresses to do so. The processor opens every access cycle by writing a command code to the command port. It then moves words one at a time through the data port. Each accepted data strobe moves one word and advances an internal word pointer. The cycle closes once the programmed number of words has been moved.

The transfer-length register holds a byte count. A buffer access moves half that many words, rounded up. The register is itself read and written through command codes, with a single data phase. The command decides the direction, and that direction is locked for the whole cycle. A data strobe against the locked direction, or one that arrives after the count is used up, has no effect on the buffer. It raises a sticky error flag instead. A new command may be written at any time. It aborts the cycle in progress and clears the error flag.

Top module: `pbx_port_access`

## Requirements
- R1: Reset is synchronous and active high. After it the block is idle, `err` is 0, `dout` is 0x0000 and the transfer-length register holds 0.
- R2: A strobe acts only on the clock where `rd_stb` or `wr_stb` rises while `cs` is 1. A strobe held high acts once. A rising strobe while `cs` is 0 has no effect.
- R3: `port_sel` = 1 selects the command port and 0 selects the data port. A write to the command port latches `din[7:0]` as the command. The codes are: 0x22 length read, 0xA2 length write, 0x40 buffer read, 0xC0 buffer write. A read strobe on the command port has no effect.
- R4: After 0xC0, each accepted data write stores `din` at the word pointer and then advances the pointer. The pointer restarts at 0 on every accepted command.
- R5: After 0x40, `dout` shows the buffer word at the pointer. Each accepted data read advances the pointer.
- R6: A buffer cycle accepts ceil(L/2) words, where L is the transfer length in bytes. Once the words are used up, data strobes are ignored and set `err`, and `dout` reads 0x0000.
- R7: A data strobe opposite to the command's direction is ignored and sets `err`. If read and write rise together, the one matching the direction is carried out and the other sets `err`.
- R8: A length access (0x22 or 0xA2) has exactly one data phase. A read returns the register value and a write replaces it.
- R9: Any command write aborts the current cycle and clears `err`. Apart from that, `err` stays set until reset.
- R10: After an unrecognised command code the block is idle. Data strobes then change neither the buffer, nor the register, nor `err`, and `dout` reads 0x0000.
- R11: The word pointer wraps to 0 after the last buffer address (DEPTH-1) when the length exceeds the buffer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cs | input | 1 | Chip select, active high |
| port_sel | input | 1 | 1 = command port, 0 = data port |
| rd_stb | input | 1 | Read strobe, acts on its rising edge |
| wr_stb | input | 1 | Write strobe, acts on its rising edge |
| din | input | 16 | Write data or command code |
| dout | output | 16 | Read data of the current data phase |
| err | output | 1 | Sticky flag for an ignored data strobe |

## Verification
Two functions can act on the same clock: carrying out a data transfer and flagging a rejected strobe. This happens when the read and write strobes rise together during a locked cycle. The bench provokes it in both buffer directions. It expects the matching half to move exactly one word and the opposite half to set the error flag, and it checks that the pointer advanced only once. A behavioural reference model predicts the output word and the flag on every clock and compares them. Further directed sequences cover the same pairing at the boundary where the last word is used up.

// File: rtl/pbx_pkg.sv
package pbx_pkg;

   typedef enum logic [2:0] {
      XM_IDLE   = 3'd0,
      XM_BUF_RD = 3'd1,
      XM_BUF_WR = 3'd2,
      XM_REG_RD = 3'd3,
      XM_REG_WR = 3'd4
   } xmode_e;

   localparam logic [7:0] CODE_LEN_RD = 8'h22;
   localparam logic [7:0] CODE_LEN_WR = 8'hA2;
   localparam logic [7:0] CODE_BUF_RD = 8'h40;
   localparam logic [7:0] CODE_BUF_WR = 8'hC0;

   function automatic xmode_e code_to_mode(input logic [7:0] code);
      case (code)
         CODE_LEN_RD: return XM_REG_RD;
         CODE_LEN_WR: return XM_REG_WR;
         CODE_BUF_RD: return XM_BUF_RD;
         CODE_BUF_WR: return XM_BUF_WR;
         default:     return XM_IDLE;
      endcase
   endfunction

   function automatic logic mode_is_read(input xmode_e m);
      return (m == XM_BUF_RD) || (m == XM_REG_RD);
   endfunction

   function automatic logic mode_is_write(input xmode_e m);
      return (m == XM_BUF_WR) || (m == XM_REG_WR);
   endfunction

endpackage

// File: rtl/pbx_strobe_edge.sv
module pbx_strobe_edge #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [N-1:0] lvl,
   output logic [N-1:0] rise
);
   initial begin
      if (N < 1) $error("pbx_strobe_edge: N must be at least 1");
   end

   for (genvar i = 0; i < N; i++) begin : g_bit
      logic prev_q;
      always_ff @(posedge clk) begin
         if (rst) prev_q <= 1'b0;
         else     prev_q <= lvl[i];
      end
      assign rise[i] = lvl[i] & ~prev_q;
   end
endmodule

// File: rtl/pbx_buf_ram.sv
module pbx_buf_ram #(
   parameter int DW    = 16,
   parameter int DEPTH = 1024,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   initial begin
      if (DEPTH < 2) $error("pbx_buf_ram: DEPTH must be at least 2");
      if (DW < 1)    $error("pbx_buf_ram: DW must be at least 1");
   end

   logic [DW-1:0] mem_q [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem_q[waddr] <= wdata;
   end

   assign rdata = mem_q[raddr];
endmodule

// File: rtl/pbx_xfer_seq.sv
module pbx_xfer_seq
   import pbx_pkg::*;
#(
   parameter int DEPTH = 1024,
   parameter int CNTW  = 16,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            cmd_take,
   input  logic [7:0]      cmd_code,
   input  logic            rd_hit,
   input  logic            wr_hit,
   input  logic [CNTW-1:0] len_bytes,
   output xmode_e          mode,
   output logic [AW-1:0]   ptr,
   output logic [CNTW-1:0] rem,
   output logic            acc_rd,
   output logic            acc_wr,
   output logic            bad,
   output logic            err
);
   initial begin
      if (CNTW < 2)  $error("pbx_xfer_seq: CNTW must be at least 2");
      if (DEPTH < 2) $error("pbx_xfer_seq: DEPTH must be at least 2");
   end

   localparam logic [CNTW:0] ONE_EXT = {{CNTW{1'b0}}, 1'b1};

   xmode_e          nmode;
   logic [CNTW:0]   words_ext;
   logic [CNTW-1:0] words;
   logic [AW-1:0]   ptr_nx;
   logic            live;

   assign nmode     = code_to_mode(cmd_code);
   assign words_ext = ({1'b0, len_bytes} + ONE_EXT) >> 1;
   assign words     = words_ext[CNTW-1:0];
   assign live      = (rem != '0);

   assign acc_rd = rd_hit && mode_is_read(mode)  && live;
   assign acc_wr = wr_hit && mode_is_write(mode) && live;
   assign bad    = (mode != XM_IDLE) &&
                   ((rd_hit && !acc_rd) || (wr_hit && !acc_wr));

   if (DEPTH == (1 << AW)) begin : g_wrap_pow2
      assign ptr_nx = ptr + 1'b1;
   end else begin : g_wrap_cmp
      assign ptr_nx = (ptr == AW'(DEPTH - 1)) ? '0 : ptr + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         mode <= XM_IDLE;
         ptr  <= '0;
         rem  <= '0;
         err  <= 1'b0;
      end else if (cmd_take) begin
         mode <= nmode;
         ptr  <= '0;
         err  <= 1'b0;
         case (nmode)
            XM_BUF_RD, XM_BUF_WR: rem <= words;
            XM_REG_RD, XM_REG_WR: rem <= {{(CNTW-1){1'b0}}, 1'b1};
            default:              rem <= '0;
         endcase
      end else begin
         if (acc_rd || acc_wr) begin
            ptr <= ptr_nx;
            rem <= rem - 1'b1;
         end
         if (bad) err <= 1'b1;
      end
   end
endmodule

// File: rtl/pbx_port_access.sv
module pbx_port_access
   import pbx_pkg::*;
#(
   parameter int DW    = 16,
   parameter int DEPTH = 1024,
   parameter int CNTW  = 16,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          cs,
   input  logic          port_sel,
   input  logic          rd_stb,
   input  logic          wr_stb,
   input  logic [DW-1:0] din,
   output logic [DW-1:0] dout,
   output logic          err
);
   initial begin
      if (DW < 8)     $error("pbx_port_access: DW must hold a command byte");
      if (CNTW > DW)  $error("pbx_port_access: CNTW must not exceed DW");
   end

   logic [1:0]      rise;
   logic            cmd_take, rd_hit, wr_hit;
   xmode_e          mode;
   logic [AW-1:0]   ptr;
   logic [CNTW-1:0] rem;
   logic            acc_rd, acc_wr, bad;
   logic [CNTW-1:0] len_q;
   logic [DW-1:0]   ram_rdata;
   logic            ram_we;

   pbx_strobe_edge #(.N(2)) u_edge (
      .clk  (clk),
      .rst  (rst),
      .lvl  ({wr_stb, rd_stb}),
      .rise (rise)
   );

   assign cmd_take = rise[1] & cs &  port_sel;
   assign wr_hit   = rise[1] & cs & ~port_sel;
   assign rd_hit   = rise[0] & cs & ~port_sel;

   pbx_xfer_seq #(.DEPTH(DEPTH), .CNTW(CNTW)) u_seq (
      .clk       (clk),
      .rst       (rst),
      .cmd_take  (cmd_take),
      .cmd_code  (din[7:0]),
      .rd_hit    (rd_hit),
      .wr_hit    (wr_hit),
      .len_bytes (len_q),
      .mode      (mode),
      .ptr       (ptr),
      .rem       (rem),
      .acc_rd    (acc_rd),
      .acc_wr    (acc_wr),
      .bad       (bad),
      .err       (err)
   );

   assign ram_we = acc_wr && (mode == XM_BUF_WR);

   pbx_buf_ram #(.DW(DW), .DEPTH(DEPTH)) u_ram (
      .clk   (clk),
      .we    (ram_we),
      .waddr (ptr),
      .wdata (din),
      .raddr (ptr),
      .rdata (ram_rdata)
   );

   always_ff @(posedge clk) begin
      if (rst)                                 len_q <= '0;
      else if (acc_wr && mode == XM_REG_WR)    len_q <= din[CNTW-1:0];
   end

   always_comb begin
      dout = '0;
      if (rem != '0) begin
         if (mode == XM_BUF_RD)      dout = ram_rdata;
         else if (mode == XM_REG_RD) dout = DW'(len_q);
      end
   end
endmodule

// File: rtl/pbx_port_access_chk.sv
module pbx_port_access_chk
   import pbx_pkg::*;
#(
   parameter int DW   = 16,
   parameter int AW   = 10,
   parameter int CNTW = 16
) (
   input logic            clk,
   input logic            rst,
   input logic            cmd_take,
   input logic            acc_rd,
   input logic            acc_wr,
   input logic            bad,
   input logic            err,
   input logic [DW-1:0]   dout,
   input xmode_e          mode,
   input logic [AW-1:0]   ptr,
   input logic [CNTW-1:0] rem
);
   p_reset_clean_r1: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> (!err && dout == '0));

   p_ptr_restart_r4: assert property (@(posedge clk) disable iff (rst)
      cmd_take |=> (ptr == '0));

   p_count_step_r6: assert property (@(posedge clk) disable iff (rst)
      (!cmd_take && (acc_rd || acc_wr)) |=> (rem == $past(rem) - 1'b1));

   p_one_dir_r7: assert property (@(posedge clk) disable iff (rst)
      $onehot0({acc_rd, acc_wr}));

   p_bad_flags_r7: assert property (@(posedge clk) disable iff (rst)
      (bad && !cmd_take) |=> err);

   p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
      (err && !cmd_take) |=> err);

   p_cmd_clears_r9: assert property (@(posedge clk) disable iff (rst)
      cmd_take |=> !err);

   p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
      (mode == XM_IDLE) |-> (dout == '0 && !acc_rd && !acc_wr && !bad));
endmodule

bind pbx_port_access pbx_port_access_chk #(.DW(DW), .AW(AW), .CNTW(CNTW)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .cmd_take (cmd_take),
   .acc_rd   (acc_rd),
   .acc_wr   (acc_wr),
   .bad      (bad),
   .err      (err),
   .dout     (dout),
   .mode     (mode),
   .ptr      (ptr),
   .rem      (rem)
);

// File: tb/pbx_port_access_tb.sv
module pbx_port_access_tb;
   localparam int CLK_PER = 10;
   localparam int DEPTH   = 1024;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cs = 1'b0, port_sel = 1'b0, rd_stb = 1'b0, wr_stb = 1'b0;
   logic [15:0] din = 16'h0;
   logic [15:0] dout;
   logic        err;

   int    n_vec = 0, n_bad = 0;
   string cur_req = "R1";
   bit    done = 0;

   always #(CLK_PER/2) clk = ~clk;

   pbx_port_access #(.DW(16), .DEPTH(DEPTH), .CNTW(16)) u_dut (
      .clk(clk), .rst(rst), .cs(cs), .port_sel(port_sel),
      .rd_stb(rd_stb), .wr_stb(wr_stb), .din(din), .dout(dout), .err(err)
   );

   // reference model: 0 idle, 1 buf read, 2 buf write, 3 len read, 4 len write
   int          m_mode = 0, m_ptr = 0, m_rem = 0, m_len = 0;
   bit          m_err = 0, m_prd = 0, m_pwr = 0;
   logic [15:0] m_mem [DEPTH];

   initial begin
      for (int i = 0; i < DEPTH; i++) m_mem[i] = 16'h0;
   end

   always @(posedge clk) begin
      if (rst) begin
         m_mode = 0; m_ptr = 0; m_rem = 0; m_len = 0; m_err = 0;
         m_prd = 0; m_pwr = 0;
      end else begin
         bit re, we, is_rd, is_wr;
         re = rd_stb && !m_prd && cs;
         we = wr_stb && !m_pwr && cs;
         if (port_sel) begin
            if (we) begin
               m_ptr = 0; m_err = 0;
               case (din[7:0])
                  8'h40: begin m_mode = 1; m_rem = (m_len + 1) / 2; end
                  8'hC0: begin m_mode = 2; m_rem = (m_len + 1) / 2; end
                  8'h22: begin m_mode = 3; m_rem = 1; end
                  8'hA2: begin m_mode = 4; m_rem = 1; end
                  default: begin m_mode = 0; m_rem = 0; end
               endcase
            end
         end else if (m_mode != 0) begin
            is_rd = (m_mode == 1 || m_mode == 3);
            is_wr = (m_mode == 2 || m_mode == 4);
            if (re) begin
               if (is_rd && m_rem > 0) begin
                  m_rem--; m_ptr = (m_ptr + 1) % DEPTH;
               end else m_err = 1;
            end
            if (we) begin
               if (is_wr && m_rem > 0) begin
                  if (m_mode == 2) m_mem[m_ptr] = din;
                  else             m_len = din;
                  m_rem--; m_ptr = (m_ptr + 1) % DEPTH;
               end else m_err = 1;
            end
         end
         m_prd = rd_stb; m_pwr = wr_stb;
      end
   end

   function automatic logic [15:0] exp_dout();
      if (m_rem > 0 && m_mode == 1) return m_mem[m_ptr];
      if (m_rem > 0 && m_mode == 3) return 16'(m_len);
      return 16'h0;
   endfunction

   always @(posedge clk) begin
      #1;
      if (!done) begin
         n_vec++;
         if (dout !== exp_dout() || err !== m_err) begin
            n_bad++;
            $display("FAIL %s t=%0t dout=%h err=%b expected dout=%h err=%b",
                     cur_req, $time, dout, err, exp_dout(), m_err);
         end
      end
   end

   task automatic bus(input bit sel, input bit r, input bit w, input bit c,
                      input logic [15:0] d);
      @(negedge clk);
      port_sel = sel; rd_stb = r; wr_stb = w; cs = c; din = d;
      @(negedge clk);
      rd_stb = 1'b0; wr_stb = 1'b0;
   endtask

   task automatic cmd(input logic [7:0] code);
      bus(1'b1, 1'b0, 1'b1, 1'b1, {8'h00, code});
   endtask

   task automatic dwr(input logic [15:0] d);
      bus(1'b0, 1'b0, 1'b1, 1'b1, d);
   endtask

   task automatic drd();
      bus(1'b0, 1'b1, 1'b0, 1'b1, 16'h0);
   endtask

   task automatic set_len(input logic [15:0] bytes);
      cmd(8'hA2); dwr(bytes);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1; n_bad++;
         $display("FAIL watchdog expired during %s", cur_req);
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      cur_req = "R1";
      repeat (3) @(negedge clk);
      rst = 1'b0;
      drd(); dwr(16'h1234);

      cur_req = "R8";
      set_len(16'd10);
      cmd(8'h22); drd();
      cur_req = "R6";
      drd();

      cur_req = "R3";
      bus(1'b1, 1'b1, 1'b0, 1'b1, 16'h00C0);
      drd();

      cur_req = "R4";
      cmd(8'hC0);
      for (int i = 0; i < 5; i++) dwr(16'hA000 + 16'(i));
      cur_req = "R6";
      dwr(16'hDEAD);

      cur_req = "R5";
      set_len(16'd9);
      cmd(8'h40);
      for (int i = 0; i < 5; i++) drd();
      cur_req = "R6";
      drd();

      cur_req = "R7";
      cmd(8'hC0);
      dwr(16'hB000); dwr(16'hB001);
      drd();
      bus(1'b0, 1'b1, 1'b1, 1'b1, 16'hB002);
      cmd(8'h40);
      drd();
      bus(1'b0, 1'b1, 1'b1, 1'b1, 16'hEEEE);
      drd(); drd(); drd();
      bus(1'b0, 1'b1, 1'b1, 1'b1, 16'hEEEE);

      cur_req = "R2";
      cmd(8'hC0);
      bus(1'b0, 1'b0, 1'b1, 1'b0, 16'h5555);
      @(negedge clk); cs = 1'b1; port_sel = 1'b0; din = 16'hC0DE; wr_stb = 1'b1;
      repeat (4) @(negedge clk);
      wr_stb = 1'b0;
      cmd(8'h40); drd(); drd();

      cur_req = "R9";
      cmd(8'h40); drd(); dwr(16'h0);
      cmd(8'h40); drd();

      cur_req = "R10";
      cmd(8'h55);
      dwr(16'h7777); drd();
      bus(1'b0, 1'b1, 1'b1, 1'b1, 16'h7777);
      cmd(8'h40); drd(); drd();

      cur_req = "R6";
      set_len(16'd0);
      cmd(8'hC0); dwr(16'h9999);
      cmd(8'h40); drd();

      cur_req = "R11";
      set_len(16'd2050);
      cmd(8'hC0);
      for (int i = 0; i < DEPTH + 1; i++) dwr(16'h4000 + 16'(i));
      set_len(16'd4);
      cmd(8'h40); drd(); drd();

      repeat (2) @(negedge clk);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule